// File: doc/BRIEF.md
# Alarm Response State Machine

This block is a small synchronous controller that tracks how a sleeper reacts to a daily alarm. Its two single-bit inputs are the alarm state and a weekday flag. It holds one of three conditions: sleeping, awake but still lying down, and out of bed. On each rising clock edge it moves to a new condition that depends on the present one and on the inputs. It also drives one control output that silences the alarm. That output depends on both the present state and the inputs, so it is a Mealy output.

An elaboration parameter, `DELAYED_OUT`, sets how the silence output reaches the port. With 0 it is combinational and follows the inputs within the same cycle. With 1 it passes through a register and shows up one clock later. The present state code is brought out so that the surrounding logic can observe it. The unused state code 2'b11 falls back to sleeping on the next edge, and the silence value computed from that code is low.

Top module: `rouse_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes sleeping (2'b00) and, in delayed mode, the registered silence output is cleared to 0.
- R2: Sleeping with `alarm_i` low: the state stays 2'b00 and the silence value is 0.
- R3: Sleeping with `alarm_i` high, whatever `weekday_i` is: the state moves to awake-in-bed (2'b01) and the silence value is 1.
- R4: Awake-in-bed with `alarm_i` high, whatever `weekday_i` is: the state stays 2'b01 and the silence value is 1.
- R5: Awake-in-bed with `alarm_i` low and `weekday_i` high: the state moves to up (2'b10) and the silence value is 0.
- R6: Awake-in-bed with `alarm_i` low and `weekday_i` low: the state returns to 2'b00 and the silence value is 0.
- R7: Up (2'b10) never leaves, whatever the inputs are, and its silence value is always 0.
- R8: With `DELAYED_OUT`=0, `silence_o` equals the silence value of the current cycle. With `DELAYED_OUT`=1, `silence_o` equals the silence value computed in the previous cycle.
- R9: `state_o` reports 2'b00 for sleeping, 2'b01 for awake-in-bed and 2'b10 for up. The code 2'b11 never appears after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every transition happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alarm_i | input | 1 | Alarm is sounding |
| weekday_i | input | 1 | High on a working day |
| state_o | output | 2 | Present state code |
| silence_o | output | 1 | Turn the alarm off (immediate or registered, set by `DELAYED_OUT`) |

## Verification
The assertions assume that `alarm_i` and `weekday_i` are stable around each rising edge and never undefined. They also assume that reset is applied before the first meaningful cycle, which is what keeps the state out of code 2'b11. The stimulus changes the inputs only at falling edges and starts every scenario with a reset. It reaches each of the three states through legal input sequences, then applies all four input combinations in turn. A design variant with each output mode is run in parallel on the same stimulus.

// File: rtl/rouse_pkg.sv
package rouse_pkg;
  localparam int STW = 2;
  localparam logic [STW-1:0] ST_SLEEP = 2'b00;
  localparam logic [STW-1:0] ST_BED   = 2'b01;
  localparam logic [STW-1:0] ST_UP    = 2'b10;

  // Next condition for a given present condition and inputs.
  function automatic logic [STW-1:0] rouse_step(input logic [STW-1:0] cur,
                                                input logic alarm,
                                                input logic wkday);
    logic [STW-1:0] nx;
    unique case (cur)
      ST_SLEEP: nx = alarm ? ST_BED : ST_SLEEP;
      ST_BED:   nx = alarm ? ST_BED : (wkday ? ST_UP : ST_SLEEP);
      ST_UP:    nx = ST_UP;
      default:  nx = ST_SLEEP;
    endcase
    return nx;
  endfunction

  // Mealy silence decision: alarm sounding while still lying down or asleep.
  function automatic logic rouse_silence(input logic [STW-1:0] cur,
                                         input logic alarm);
    logic s;
    unique case (cur)
      ST_SLEEP, ST_BED: s = alarm;
      default:          s = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rouse_next.sv
module rouse_next
  import rouse_pkg::*;
(
  input  logic [STW-1:0] cur_i,
  input  logic           alarm_i,
  input  logic           weekday_i,
  output logic [STW-1:0] nxt_o,
  output logic           mealy_o
);
  always_comb begin
    nxt_o   = rouse_step(cur_i, alarm_i, weekday_i);
    mealy_o = rouse_silence(cur_i, alarm_i);
  end
endmodule

// File: rtl/rouse_state_reg.sv
module rouse_state_reg
  import rouse_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [STW-1:0] nxt_i,
  output logic [STW-1:0] cur_o
);
  always_ff @(posedge clk) begin
    if (rst) cur_o <= ST_SLEEP;
    else     cur_o <= nxt_i;
  end
endmodule

// File: rtl/rouse_out_stage.sv
module rouse_out_stage #(
  parameter bit DELAYED_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic mealy_i,
  output logic silence_o
);
  generate
    if (DELAYED_OUT) begin : g_reg
      logic silence_q;
      always_ff @(posedge clk) begin
        if (rst) silence_q <= 1'b0;
        else     silence_q <= mealy_i;
      end
      assign silence_o = silence_q;
    end else begin : g_imm
      assign silence_o = mealy_i;
    end
  endgenerate
endmodule

// File: rtl/rouse_fsm.sv
module rouse_fsm
  import rouse_pkg::*;
#(
  parameter bit DELAYED_OUT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       alarm_i,
  input  logic       weekday_i,
  output logic [1:0] state_o,
  output logic       silence_o
);
  logic [STW-1:0] cur_w;
  logic [STW-1:0] nxt_w;
  logic           mealy_w;

  rouse_next u_next (
    .cur_i     (cur_w),
    .alarm_i   (alarm_i),
    .weekday_i (weekday_i),
    .nxt_o     (nxt_w),
    .mealy_o   (mealy_w)
  );

  rouse_state_reg u_state (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (nxt_w),
    .cur_o (cur_w)
  );

  rouse_out_stage #(.DELAYED_OUT(DELAYED_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .mealy_i   (mealy_w),
    .silence_o (silence_o)
  );

  assign state_o = cur_w;
endmodule

// File: rtl/rouse_chk.sv
module rouse_chk #(
  parameter bit DELAYED_OUT = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       alarm_i,
  input logic       weekday_i,
  input logic [1:0] state_o,
  input logic       silence_o,
  input logic [1:0] nxt_w,
  input logic       mealy_w
);
  p_reset_r1: assert property (@(posedge clk) rst |=> state_o == 2'b00);
  p_stay_asleep_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && !alarm_i) |=> state_o == 2'b00);
  p_wake_r3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && alarm_i) |=> state_o == 2'b01);
  p_hold_bed_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01 && alarm_i) |=> state_o == 2'b01);
  p_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01 && !alarm_i && weekday_i) |=> state_o == 2'b10);
  p_doze_r6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01 && !alarm_i && !weekday_i) |=> state_o == 2'b00);
  p_absorb_r7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b10) |=> state_o == 2'b10);
  p_up_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b10) |-> !mealy_w);
  p_next_legal_r9: assert property (@(posedge clk) disable iff (rst)
    nxt_w != 2'b11);
  p_code_r9: assert property (@(posedge clk) disable iff (rst)
    state_o != 2'b11);

  generate
    if (DELAYED_OUT) begin : g_dly
      p_delay_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> silence_o == $past(alarm_i && !state_o[1]));
      p_reset_out_r1: assert property (@(posedge clk) rst |=> !silence_o);
    end else begin : g_imm
      p_imm_r8: assert property (@(posedge clk) disable iff (rst)
        silence_o == (alarm_i && (state_o == 2'b00 || state_o == 2'b01)));
    end
  endgenerate
endmodule

bind rouse_fsm rouse_chk #(.DELAYED_OUT(DELAYED_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .alarm_i   (alarm_i),
  .weekday_i (weekday_i),
  .state_o   (state_o),
  .silence_o (silence_o),
  .nxt_w     (nxt_w),
  .mealy_w   (mealy_w)
);

// File: tb/sim_rouse_fsm.sv
`timescale 1ns/1ps
module sim_rouse_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alarm = 1'b0;
  logic wk = 1'b0;
  logic [1:0] st0, st1;
  logic sil0, sil1;
  int checks = 0;
  int errors = 0;
  logic [1:0] m_st = 2'b00;
  logic m_prev = 1'b0;
  string prev_tag = "R1";

  always #4 clk = ~clk;

  rouse_fsm #(.DELAYED_OUT(1'b0)) u0 (
    .clk(clk), .rst(rst), .alarm_i(alarm), .weekday_i(wk),
    .state_o(st0), .silence_o(sil0));
  rouse_fsm #(.DELAYED_OUT(1'b1)) u1 (
    .clk(clk), .rst(rst), .alarm_i(alarm), .weekday_i(wk),
    .state_o(st1), .silence_o(sil1));

  // Reference model written as bit arithmetic on the codes.
  function automatic logic [1:0] ref_next(logic [1:0] s, logic a, logic w);
    if (s == 2'b10) return 2'b10;
    if (a)          return 2'b01;
    return (s == 2'b01 && w) ? 2'b10 : 2'b00;
  endfunction
  function automatic logic ref_out(logic [1:0] s, logic a);
    return a & ~s[1];
  endfunction
  function automatic string tag_of(logic [1:0] s, logic a, logic w);
    if (s == 2'b00) return a ? "R3" : "R2";
    if (s == 2'b01) return a ? "R4" : (w ? "R5" : "R6");
    return "R7";
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic a, logic w);
    logic e;
    @(negedge clk);
    alarm = a; wk = w;
    #1;
    e = ref_out(m_st, a);
    chk({prev_tag, "/R9 state u0"}, st0, m_st);
    chk({prev_tag, "/R9 state u1"}, st1, m_st);
    chk({tag_of(m_st, a, w), "/R8 immediate silence"}, {1'b0, sil0}, {1'b0, e});
    chk("R8 delayed silence", {1'b0, sil1}, {1'b0, m_prev});
    prev_tag = tag_of(m_st, a, w);
    m_prev = e;
    m_st = ref_next(m_st, a, w);
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; alarm = 1'b1; wk = 1'b1;
    @(negedge clk);
    alarm = 1'b0; wk = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 state u0", st0, 2'b00);
    chk("R1 state u1", st1, 2'b00);
    chk("R1 delayed out cleared", {1'b0, sil1}, 2'b00);
    rst = 1'b0;
    m_st = 2'b00; m_prev = 1'b0; prev_tag = "R1";
    @(posedge clk);
  endtask

  initial begin
    do_reset();
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 4; c++) begin
        do_reset();
        if (s >= 1) step(1'b1, 1'b0);
        if (s == 2) step(1'b0, 1'b1);
        step(c[1], c[0]);
        step(c[0], c[1]);
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
      end
    end
    // Long alarm hold then weekend doze, then weekday rise.
    do_reset();
    for (int k = 0; k < 4; k++) step(1'b1, k[0]);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    for (int k = 0; k < 4; k++) step(k[1], k[0]);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule